// File: doc/BRIEF.md
# Sixteen-Bit Interval and PWM Counter with Trigger Control

This block is a single 16-bit counter channel. It runs in one of three modes. As an interval timer it counts up from zero to a programmed limit, returns to zero and raises an interrupt pulse. As a pulse-width modulator it drives an output pair: a main output and its exact inverse. As a width meter it measures how long an external trigger input stays high.

Software starts and stops the channel with command bits in a control write. When enabled, the edges of the external trigger input can also start and stop it. The counter advances either on every system clock or once per rising edge of an external event input. The trigger and event inputs are asynchronous. Each passes through a two-flop synchroniser, and its edges are detected in the system clock domain.

Period and duty writes go to holding registers. They reach the comparator only when the counter wraps, or right away while the channel is stopped. This means a new setting never shortens a running period.

Top module: `pwm_trig_timer`

## Requirements
- R1: After reset the count and the captured width are 0, `pwm_out` is 0, `pwm_n_out` is 1, `irq` is 0 and the channel is stopped.
- R2: In interval mode (mode code 0) or PWM mode (code 1), a running counter advances by one per tick. On the tick where the count is at or above the active period, the count becomes 0 instead, and `irq` is high for exactly that one cycle. Interrupts are therefore period+1 ticks apart.
- R3: In PWM mode `pwm_out` is high exactly while the count is below the active duty. In any other mode `pwm_out` stays low.
- R4: A duty of 0 keeps `pwm_out` low for the whole period. A duty above the period keeps it high for the whole period.
- R5: `pwm_n_out` is always the inverse of `pwm_out`.
- R6: A period or duty written while the channel runs takes effect only after the next wrap. A value written while the channel is stopped takes effect on the next cycle.
- R7: A write to `wr_sel` = 2 sets the configuration: bits [1:0] the mode, bit 2 the event clock, bit 3 trigger control. In the same write, bit 4 starts the channel and bit 5 stops it. Stop wins when both bits are set. A stopped counter holds its value.
- R8: With bit 3 set, in interval or PWM mode, a rising trigger edge starts the channel and a falling edge stops it. Each edge acts on the third clock edge after the input changes. With bit 3 clear, the trigger has no effect in these modes.
- R9: In width mode (code 2), a rising trigger edge clears the count and starts the channel. The falling edge latches the number of ticks seen while the trigger was high into `cap_out`, stops the channel and pulses `irq` once.
- R10: With bit 2 set, the counter advances once per rising edge of `event_in` and never otherwise.

Registers selected by `wr_sel`: 0 is the period, 1 is the duty, 2 is the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 duty, 2 control |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | Asynchronous external trigger |
| event_in | input | 1 | Asynchronous external count event |
| pwm_out | output | 1 | PWM output |
| pwm_n_out | output | 1 | Complementary PWM output |
| irq | output | 1 | One-cycle interrupt pulse |
| cnt_out | output | 16 | Current count |
| cap_out | output | 16 | Last captured pulse width |

## Verification
The PWM path is driven with a table of period and duty pairs: a duty inside the period, zero, equal to the period, one above it, far above it, and a period of zero. Counting the high cycles in one full period for each pair distinguishes a correct less-than compare from an off-by-one or an inverted compare. The interval path is checked by the spacing of its interrupts before and after a period change made mid-run, which exposes an unbuffered period write. Trigger pulses of known length are applied in gated and width modes, and event pulses are counted under the external clock. These show whether the two trigger edges use matching latency and whether ticks are gated correctly.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD = 2'd0,
    MODE_PWM    = 2'd1,
    MODE_WIDTH  = 2'd2,
    MODE_SPARE  = 2'd3
  } ptt_mode_e;

  localparam logic [1:0] SEL_PERIOD = 2'd0;
  localparam logic [1:0] SEL_DUTY   = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;

  localparam int CTRL_EVT   = 2;
  localparam int CTRL_TRG   = 3;
  localparam int CTRL_START = 4;
  localparam int CTRL_STOP  = 5;
endpackage

// File: rtl/ptt_sync.sv
module ptt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic now,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], d};
  end

  assign now  = sh[STAGES-1];
  assign prev = sh[STAGES];
endmodule

// File: rtl/ptt_cfg.sv
module ptt_cfg
  import ptt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_buf,
  output logic [W-1:0] duty_buf,
  output ptt_mode_e    mode_q,
  output logic         evt_sel,
  output logic         trig_en,
  output logic         sw_start,
  output logic         sw_stop
);
  logic ctrl_wr;
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign sw_start = ctrl_wr && wr_data[CTRL_START];
  assign sw_stop  = ctrl_wr && wr_data[CTRL_STOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf  <= '0;
      duty_buf <= '0;
      mode_q   <= MODE_RELOAD;
      evt_sel  <= 1'b0;
      trig_en  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PERIOD: per_buf  <= wr_data;
        SEL_DUTY:   duty_buf <= wr_data;
        SEL_CTRL: begin
          mode_q  <= ptt_mode_e'(wr_data[1:0]);
          evt_sel <= wr_data[CTRL_EVT];
          trig_en <= wr_data[CTRL_TRG];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptt_core.sv
module ptt_core
  import ptt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ptt_mode_e    mode,
  input  logic         evt_sel,
  input  logic         trig_en,
  input  logic         sw_start,
  input  logic         sw_stop,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  input  logic         trig_rise,
  input  logic         trig_fall,
  input  logic         evt_rise,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] duty_act,
  output logic         run_q,
  output logic         pwm_q,
  output logic         pwm_n_q,
  output logic         irq_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         tick, width_mode, wrap, capture, run_nxt, pwm_nxt;
  logic [W-1:0] per_act, cnt_nxt, per_nxt, duty_nxt, tick_w;

  always_comb begin
    width_mode = (mode == MODE_WIDTH);
    tick       = evt_sel ? evt_rise : 1'b1;
    tick_w     = tick ? ONE : '0;
    wrap       = !width_mode && run_q && tick && (cnt_q >= per_act);
    capture    = width_mode && run_q && trig_fall;

    run_nxt = run_q;
    if (width_mode) begin
      if (trig_rise || sw_start) run_nxt = 1'b1;
      if (trig_fall || sw_stop)  run_nxt = 1'b0;
    end else begin
      if (sw_start || (trig_en && trig_rise)) run_nxt = 1'b1;
      if (sw_stop  || (trig_en && trig_fall)) run_nxt = 1'b0;
    end

    cnt_nxt = cnt_q;
    if (width_mode && trig_rise) cnt_nxt = '0;
    else if (wrap)               cnt_nxt = '0;
    else if (run_q && tick)      cnt_nxt = cnt_q + ONE;

    if (!run_q || wrap) begin
      per_nxt  = per_buf;
      duty_nxt = duty_buf;
    end else begin
      per_nxt  = per_act;
      duty_nxt = duty_act;
    end

    pwm_nxt = (mode == MODE_PWM) && (cnt_nxt < duty_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      cap_q    <= '0;
      per_act  <= '0;
      duty_act <= '0;
      run_q    <= 1'b0;
      pwm_q    <= 1'b0;
      pwm_n_q  <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      per_act  <= per_nxt;
      duty_act <= duty_nxt;
      run_q    <= run_nxt;
      pwm_q    <= pwm_nxt;
      pwm_n_q  <= !pwm_nxt;
      irq_q    <= wrap || capture;
      if (capture) cap_q <= cnt_q + tick_w;
    end
  end
endmodule

// File: rtl/pwm_trig_timer.sv
module pwm_trig_timer
  import ptt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  input  logic             event_in,
  output logic             pwm_out,
  output logic             pwm_n_out,
  output logic             irq,
  output logic [CNT_W-1:0] cnt_out,
  output logic [CNT_W-1:0] cap_out
);
  logic [CNT_W-1:0] per_buf, duty_buf, duty_act;
  ptt_mode_e        mode_q;
  logic             evt_sel, trig_en, sw_start, sw_stop, run_q;
  logic             trig_now, trig_prev, evt_now, evt_prev;
  logic             trig_rise, trig_fall, evt_rise;

  ptt_sync #(.STAGES(SYNC_DEPTH)) u_trig_sync (
    .clk(clk), .rst(rst), .d(trig_in), .now(trig_now), .prev(trig_prev)
  );
  ptt_sync #(.STAGES(SYNC_DEPTH)) u_evt_sync (
    .clk(clk), .rst(rst), .d(event_in), .now(evt_now), .prev(evt_prev)
  );

  assign trig_rise = trig_now && !trig_prev;
  assign trig_fall = !trig_now && trig_prev;
  assign evt_rise  = evt_now && !evt_prev;

  ptt_cfg #(.W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .per_buf(per_buf), .duty_buf(duty_buf), .mode_q(mode_q),
    .evt_sel(evt_sel), .trig_en(trig_en), .sw_start(sw_start), .sw_stop(sw_stop)
  );

  ptt_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q), .evt_sel(evt_sel), .trig_en(trig_en),
    .sw_start(sw_start), .sw_stop(sw_stop), .per_buf(per_buf), .duty_buf(duty_buf),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .evt_rise(evt_rise),
    .cnt_q(cnt_out), .cap_q(cap_out), .duty_act(duty_act), .run_q(run_q),
    .pwm_q(pwm_out), .pwm_n_q(pwm_n_out), .irq_q(irq)
  );
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt_out,
  input logic [W-1:0] cap_out,
  input logic [W-1:0] duty_act,
  input logic [1:0]   mode_q,
  input logic         run_q,
  input logic         pwm_out,
  input logic         pwm_n_out,
  input logic         irq
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state seen one cycle after a reset cycle
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_state: assert (cnt_out == '0 && cap_out == '0 && !pwm_out &&
                                pwm_n_out && !irq && !run_q);
    end
  end

  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    pwm_n_out == !pwm_out);

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (irq && mode_q != 2'd2) |-> (cnt_out == '0));

  a_r9_capture_stops: assert property (@(posedge clk) disable iff (rst)
    (irq && mode_q == 2'd2) |-> !run_q);

  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && mode_q != 2'd2) |=> $stable(cnt_out));

  a_r3_duty_compare: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && $past(mode_q) == 2'd1) |-> (pwm_out == (cnt_out < duty_act)));
endmodule

bind pwm_trig_timer ptt_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_out(cnt_out), .cap_out(cap_out),
  .duty_act(duty_act), .mode_q(mode_q), .run_q(run_q),
  .pwm_out(pwm_out), .pwm_n_out(pwm_n_out), .irq(irq)
);

// File: tb/sim_pwm_trig_timer.sv
`timescale 1ns/1ps
module sim_pwm_trig_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        trig_in = 1'b0;
  logic        event_in = 1'b0;
  logic        pwm_out, pwm_n_out, irq;
  logic [15:0] cnt_out, cap_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int irq_seen = 0;

  always #4 clk = ~clk;

  pwm_trig_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_in(trig_in), .event_in(event_in), .pwm_out(pwm_out),
    .pwm_n_out(pwm_n_out), .irq(irq), .cnt_out(cnt_out), .cap_out(cap_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) irq_seen <= irq_seen + 1;
  end

  // period, duty, expected high cycles per period
  localparam logic [47:0] PWM_VEC [7] = '{
    {16'd9, 16'd3,  16'd3},
    {16'd9, 16'd0,  16'd0},
    {16'd9, 16'd9,  16'd9},
    {16'd9, 16'd10, 16'd10},
    {16'd4, 16'd2,  16'd2},
    {16'd7, 16'd20, 16'd8},
    {16'd0, 16'd1,  16'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic [1:0] m, input logic ev,
                                      input logic tg, input logic st, input logic sp);
    return {10'd0, sp, st, tg, ev, m};
  endfunction

  task automatic wait_irq(output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!irq && guard < 200);
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t0, t1, t2, c0, hi, bad, s0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_out, 0);
    chk("R1 cap", cap_out, 0);
    chk("R1 pwm", pwm_out, 0);
    chk("R1 pwm_n", pwm_n_out, 1);
    chk("R1 irq", irq, 0);

    // R3 R4 R5 PWM vector table
    for (int i = 0; i < 7; i++) begin
      logic [15:0] p, d, e;
      {p, d, e} = PWM_VEC[i];
      wr(2'd2, ctl(2'd1, 0, 0, 0, 1));
      wr(2'd0, p);
      wr(2'd1, d);
      wr(2'd2, ctl(2'd1, 0, 0, 1, 0));
      idle(3);
      hi = 0; bad = 0;
      for (int k = 0; k <= int'(p); k++) begin
        @(negedge clk);
        hi += int'(pwm_out);
        if (pwm_n_out !== ~pwm_out) bad++;
      end
      chk("R3/R4 high cycles", hi, int'(e));
      chk("R5 complement mismatches", bad, 0);
    end

    // R2 interval mode
    wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
    wr(2'd0, 16'd4);
    wr(2'd2, ctl(2'd0, 0, 0, 1, 0));
    wait_irq(t0);
    chk("R2 count at irq", cnt_out, 0);
    wait_irq(t1);
    chk("R2 irq spacing", t1 - t0, 5);
    chk("R3 pwm low in interval mode", pwm_out, 0);
    // R6 period change while running
    wr(2'd0, 16'd9);
    wait_irq(t2);
    chk("R6 old period kept", t2 - t1, 5);
    wait_irq(t0);
    chk("R6 new period after wrap", t0 - t2, 10);

    // R7 software stop and start
    wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
    idle(1);
    c0 = cnt_out;
    idle(8);
    chk("R7 hold while stopped", cnt_out, c0);
    wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
    idle(5);
    chk("R7 stop wins", cnt_out, c0);
    wr(2'd2, ctl(2'd0, 0, 0, 1, 0));
    idle(3);
    chk("R7 start resumes", int'(cnt_out != c0[15:0]), 1);

    // R8 trigger gating
    wr(2'd2, ctl(2'd0, 0, 1, 0, 1));
    wr(2'd0, 16'd1000);
    idle(2);
    c0 = cnt_out;
    trig_in = 1'b1;
    idle(30);
    trig_in = 1'b0;
    idle(30);
    chk("R8 ticks while trigger high", cnt_out, c0 + 30);
    wr(2'd2, ctl(2'd0, 0, 0, 0, 0));
    c0 = cnt_out;
    trig_in = 1'b1;
    idle(10);
    trig_in = 1'b0;
    idle(10);
    chk("R8 trigger ignored when disabled", cnt_out, c0);

    // R9 width measurement
    wr(2'd2, ctl(2'd2, 0, 0, 0, 1));
    idle(2);
    s0 = irq_seen;
    trig_in = 1'b1;
    idle(37);
    trig_in = 1'b0;
    idle(6);
    chk("R9 width 37", cap_out, 37);
    chk("R9 one irq", irq_seen - s0, 1);
    c0 = cnt_out;
    idle(5);
    chk("R9 stopped after capture", cnt_out, c0);
    trig_in = 1'b1;
    idle(5);
    trig_in = 1'b0;
    idle(6);
    chk("R9 width 5", cap_out, 5);

    // R10 event clock
    wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
    wr(2'd2, ctl(2'd0, 1, 0, 1, 0));
    idle(3);
    c0 = cnt_out;
    for (int k = 0; k < 7; k++) begin
      event_in = 1'b1; idle(3);
      event_in = 1'b0; idle(3);
    end
    idle(6);
    chk("R10 seven events", cnt_out, c0 + 7);
    idle(20);
    chk("R10 no events no ticks", cnt_out, c0 + 7);

    // R1 reset in the middle of operation
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cnt after reset", cnt_out, 0);
    chk("R1 cap after reset", cap_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule